// File: doc/BRIEF.md
# Floating-Point Status Word Register

This block holds the 16-bit status word of a stack-based floating-point coprocessor. It keeps the three-bit pointer to the register that is currently the top of the stack. It also keeps the four condition code bits, the sticky exception flags and the sticky stack-fault flag. The CPU can read the whole word through one port.

Two bits of the word are never stored. The error-summary bit is recomputed at all times from the exception flags and the mask vector supplied by the control word, and the busy bit copies it. The active-low error output follows the summary bit with no register in between. A change of mask, or a restore of the whole word, therefore shows on the pin in the cycle the new state takes effect.

Stack push and pop strobes move the pointer. Exception-report strobes and stack-fault reports are ORed into the sticky flags. A clear command wipes the flags. A full-word load port restores the environment.

Top module: `fstat_word`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the status word reads 0x0000 and `err_n_o` is 1.
- R2: The pointer occupies bits 13:11. A cycle with only `push_i` lowers it by one modulo 8. A cycle with only `pop_i` raises it by one modulo 8. A cycle with both, or with neither, leaves it unchanged.
- R3: Exception flags occupy bits 5:0. A 1 on `exc_set_i[k]` sets bit k at the next edge. A set flag stays set until a clear or a load.
- R4: When `clr_exc_i` is high and no load occurs, bits 6:0 take only the reports presented in that same cycle. Bits 14:8 are unchanged.
- R5: Bit 7 is 1 exactly when some bit k of 5:0 is 1 while `mask_i[k]` is 0 (a mask bit of 1 masks its flag). It follows `mask_i` within the same cycle.
- R6: Bit 15 always equals bit 7.
- R7: `err_n_o` is 0 exactly when bit 7 is 1, in the same cycle.
- R8: `sf_set_i` sets bit 6 (sticky) and writes `sf_ovf_i` into bit 9 (C1): 1 marks overflow and 0 marks underflow. This write takes priority over a condition-code write in the same cycle.
- R9: `cc_we_i` writes `cc_i` = {C3,C2,C1,C0} into bits 14, 10, 9 and 8.
- R10: `ld_we_i` loads bits 14:8 and 6:0 from `ld_word_i` at the next edge. The load overrides push, pop, clear, reports and condition-code writes. Bits 7 and 15 of the loaded value are ignored and recomputed, so `err_n_o` reflects the loaded flags in the first cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Stack push: pointer minus one |
| pop_i | input | 1 | Stack pop: pointer plus one |
| exc_set_i | input | 6 | Exception report strobes, one per flag |
| sf_set_i | input | 1 | Stack fault report |
| sf_ovf_i | input | 1 | Stack fault kind: 1 overflow, 0 underflow |
| cc_we_i | input | 1 | Condition code write enable |
| cc_i | input | 4 | New condition code {C3,C2,C1,C0} |
| mask_i | input | 6 | Exception masks from the control word, 1 = masked |
| ld_we_i | input | 1 | Full-word load (environment restore) |
| ld_word_i | input | 16 | Word to load |
| clr_exc_i | input | 1 | Clear exception and stack-fault flags |
| sw_o | output | 16 | Status word read port |
| err_n_o | output | 1 | Active-low error output |

## Verification
The summary bit is swept over all 64 flag patterns against all 64 mask patterns. A design that stored the summary bit, or inverted the meaning of a mask bit, would show a stale or wrong bit 7 or error pin on the first mask change. Words are loaded with bits 7 and 15 set opposite to what the flags imply. This catches a design that copies those bits from the data or delays the pin by a cycle.

The pointer is walked from all eight values through push, pop and both at once, which exposes a wrong direction or a broken wrap from 0 to 7. The corner cases of priority are driven: a clear together with a fresh report, a stack fault together with a condition-code write, and a load together with every other command. A long pseudo-random run then compares the full word against a model in the bench.

// File: rtl/fstat_pkg.sv
package fstat_pkg;
   localparam int unsigned SW_W     = 16;
   localparam int unsigned EXC_N    = 6;
   localparam int unsigned PTR_W    = 3;
   localparam int unsigned CC_N     = 4;

   // Bit positions used by neighbours decoding the word
   localparam int unsigned POS_SF   = 6;
   localparam int unsigned POS_ES   = 7;
   localparam int unsigned POS_C0   = 8;
   localparam int unsigned POS_C1   = 9;
   localparam int unsigned POS_C2   = 10;
   localparam int unsigned POS_PTR  = 11;
   localparam int unsigned POS_C3   = 14;
   localparam int unsigned POS_BUSY = 15;

   typedef struct packed {
      logic             busy;
      logic             c3;
      logic [PTR_W-1:0] ptr;
      logic             c2;
      logic             c1;
      logic             c0;
      logic             es;
      logic             sf;
      logic [EXC_N-1:0] exc;
   } sword_t;

   // Condition code vector order: {C3,C2,C1,C0}
   localparam int unsigned CC_IDX_C1 = 1;
endpackage

// File: rtl/fstat_ptr.sv
module fstat_ptr #(
   parameter int unsigned PTR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic             ld_i,
   input  logic [PTR_W-1:0] ld_ptr_i,
   output logic [PTR_W-1:0] ptr_o
);
   localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

   logic [PTR_W-1:0] ptr_q, ptr_d;

   always_comb begin
      ptr_d = ptr_q;
      if (ld_i) begin
         ptr_d = ld_ptr_i;
      end else if (push_i && !pop_i) begin
         ptr_d = ptr_q - ONE;
      end else if (pop_i && !push_i) begin
         ptr_d = ptr_q + ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_d;
   end

   assign ptr_o = ptr_q;
endmodule

// File: rtl/fstat_flags.sv
module fstat_flags #(
   parameter int unsigned EXC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EXC_W-1:0] set_i,
   input  logic             sf_set_i,
   input  logic             clr_i,
   input  logic             ld_i,
   input  logic [EXC_W-1:0] ld_exc_i,
   input  logic             ld_sf_i,
   output logic [EXC_W-1:0] exc_o,
   output logic             sf_o
);
   logic [EXC_W-1:0] exc_q;
   logic             sf_q;

   // One sticky cell per exception flag
   for (genvar k = 0; k < EXC_W; k++) begin : g_cell
      logic keep;
      assign keep = exc_q[k] && !clr_i;
      always_ff @(posedge clk) begin
         if (!rst_n)    exc_q[k] <= 1'b0;
         else if (ld_i) exc_q[k] <= ld_exc_i[k];
         else           exc_q[k] <= keep || set_i[k];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    sf_q <= 1'b0;
      else if (ld_i) sf_q <= ld_sf_i;
      else           sf_q <= (sf_q && !clr_i) || sf_set_i;
   end

   assign exc_o = exc_q;
   assign sf_o  = sf_q;
endmodule

// File: rtl/fstat_cc.sv
module fstat_cc #(
   parameter int unsigned CC_W   = 4,
   parameter int unsigned C1_IDX = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_i,
   input  logic [CC_W-1:0] cc_i,
   input  logic            sf_set_i,
   input  logic            sf_ovf_i,
   input  logic            ld_i,
   input  logic [CC_W-1:0] ld_cc_i,
   output logic [CC_W-1:0] cc_o
);
   logic [CC_W-1:0] cc_q, cc_d;

   always_comb begin
      cc_d = cc_q;
      if (ld_i) begin
         cc_d = ld_cc_i;
      end else begin
         if (we_i)     cc_d = cc_i;
         if (sf_set_i) cc_d[C1_IDX] = sf_ovf_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cc_q <= '0;
      else        cc_q <= cc_d;
   end

   assign cc_o = cc_q;
endmodule

// File: rtl/fstat_summary.sv
module fstat_summary #(
   parameter int unsigned EXC_W = 6
) (
   input  logic [EXC_W-1:0] exc_i,
   input  logic [EXC_W-1:0] mask_i,
   output logic             es_o
);
   logic [EXC_W-1:0] live;

   for (genvar k = 0; k < EXC_W; k++) begin : g_live
      assign live[k] = exc_i[k] & ~mask_i[k];
   end

   assign es_o = |live;
endmodule

// File: rtl/fstat_word.sv
module fstat_word
   import fstat_pkg::*;
#(
   parameter int unsigned EXC_W = fstat_pkg::EXC_N,
   parameter int unsigned PTR_W = fstat_pkg::PTR_W
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        push_i,
   input  logic        pop_i,
   input  logic [5:0]  exc_set_i,
   input  logic        sf_set_i,
   input  logic        sf_ovf_i,
   input  logic        cc_we_i,
   input  logic [3:0]  cc_i,
   input  logic [5:0]  mask_i,
   input  logic        ld_we_i,
   input  logic [15:0] ld_word_i,
   input  logic        clr_exc_i,
   output logic [15:0] sw_o,
   output logic        err_n_o
);
   localparam int unsigned TOTAL_W = EXC_W + PTR_W + 7;

   initial begin
      assert (TOTAL_W == SW_W) else $error("fstat_word: field widths do not fill the word");
      assert (EXC_W == EXC_N)  else $error("fstat_word: exception count fixed by layout");
   end

   sword_t           ld_view, word;
   logic [EXC_W-1:0] exc;
   logic             sf, es;
   logic [PTR_W-1:0] ptr;
   logic [CC_N-1:0]  cc, ld_cc;

   assign ld_view = sword_t'(ld_word_i);
   assign ld_cc   = {ld_view.c3, ld_view.c2, ld_view.c1, ld_view.c0};

   fstat_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_i   (push_i),
      .pop_i    (pop_i),
      .ld_i     (ld_we_i),
      .ld_ptr_i (ld_view.ptr),
      .ptr_o    (ptr)
   );

   fstat_flags #(.EXC_W(EXC_W)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (exc_set_i),
      .sf_set_i (sf_set_i),
      .clr_i    (clr_exc_i),
      .ld_i     (ld_we_i),
      .ld_exc_i (ld_view.exc),
      .ld_sf_i  (ld_view.sf),
      .exc_o    (exc),
      .sf_o     (sf)
   );

   fstat_cc #(.CC_W(CC_N), .C1_IDX(CC_IDX_C1)) u_cc (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (cc_we_i),
      .cc_i     (cc_i),
      .sf_set_i (sf_set_i),
      .sf_ovf_i (sf_ovf_i),
      .ld_i     (ld_we_i),
      .ld_cc_i  (ld_cc),
      .cc_o     (cc)
   );

   fstat_summary #(.EXC_W(EXC_W)) u_sum (
      .exc_i  (exc),
      .mask_i (mask_i),
      .es_o   (es)
   );

   always_comb begin
      word      = '0;
      word.busy = es;
      word.c3   = cc[3];
      word.ptr  = ptr;
      word.c2   = cc[2];
      word.c1   = cc[1];
      word.c0   = cc[0];
      word.es   = es;
      word.sf   = sf;
      word.exc  = exc;
   end

   assign sw_o    = word;
   assign err_n_o = ~es;
endmodule

// File: rtl/fstat_word_chk.sv
module fstat_word_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        push_i,
   input logic        pop_i,
   input logic [5:0]  exc_set_i,
   input logic        sf_set_i,
   input logic        sf_ovf_i,
   input logic        cc_we_i,
   input logic [3:0]  cc_i,
   input logic [5:0]  mask_i,
   input logic        ld_we_i,
   input logic [15:0] ld_word_i,
   input logic        clr_exc_i,
   input logic [15:0] sw_o,
   input logic        err_n_o
);
   assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && !ld_we_i) |=> sw_o[13:11] == 3'($past(sw_o[13:11]) - 3'd1));

   assert_pop_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && !ld_we_i) |=> sw_o[13:11] == 3'($past(sw_o[13:11]) + 3'd1));

   assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_we_i && !clr_exc_i) |=> (sw_o[5:0] & $past(sw_o[5:0])) == $past(sw_o[5:0]));

   assert_report_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_we_i) |=> (sw_o[5:0] & $past(exc_set_i)) == $past(exc_set_i));

   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_exc_i && !ld_we_i) |=> (sw_o[5:0] == $past(exc_set_i)) && (sw_o[6] == $past(sf_set_i)));

   assert_summary_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sw_o[7] == (|(sw_o[5:0] & ~mask_i)));

   assert_busy_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sw_o[15] == sw_o[7]);

   assert_err_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_n_o == !sw_o[7]);

   assert_fault_kind_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sf_set_i && !ld_we_i) |=> sw_o[6] && (sw_o[9] == $past(sf_ovf_i)));

   assert_cc_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cc_we_i && !sf_set_i && !ld_we_i) |=> {sw_o[14], sw_o[10], sw_o[9], sw_o[8]} == $past(cc_i));

   assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ld_we_i |=> (sw_o[14:8] == $past(ld_word_i[14:8])) && (sw_o[6:0] == $past(ld_word_i[6:0])));
endmodule

bind fstat_word fstat_word_chk u_chk (.*);

// File: tb/fstat_word_tb.sv
module fstat_word_tb;
   localparam time CLK_PER = 10ns;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        push_i, pop_i, sf_set_i, sf_ovf_i, cc_we_i, ld_we_i, clr_exc_i;
   logic [5:0]  exc_set_i, mask_i;
   logic [3:0]  cc_i;
   logic [15:0] ld_word_i;
   logic [15:0] sw_o;
   logic        err_n_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // Bench model of the stored state
   logic [2:0] m_ptr;
   logic [5:0] m_exc;
   logic       m_sf;
   logic [3:0] m_cc;

   always #(CLK_PER/2) clk = ~clk;

   fstat_word u_dut (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
      .exc_set_i(exc_set_i), .sf_set_i(sf_set_i), .sf_ovf_i(sf_ovf_i),
      .cc_we_i(cc_we_i), .cc_i(cc_i), .mask_i(mask_i), .ld_we_i(ld_we_i),
      .ld_word_i(ld_word_i), .clr_exc_i(clr_exc_i), .sw_o(sw_o), .err_n_o(err_n_o)
   );

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic exp_es(input logic [5:0] f, input logic [5:0] m);
      int hits = 0;
      for (int k = 0; k < 6; k++) if (f[k] == 1'b1 && m[k] == 1'b0) hits++;
      return hits != 0;
   endfunction

   function automatic logic [15:0] exp_word();
      logic e;
      e = exp_es(m_exc, mask_i);
      return {e, m_cc[3], m_ptr, m_cc[2], m_cc[1], m_cc[0], e, m_sf, m_exc};
   endfunction

   task automatic idle();
      push_i = 0; pop_i = 0; sf_set_i = 0; sf_ovf_i = 0; cc_we_i = 0;
      ld_we_i = 0; clr_exc_i = 0; exc_set_i = '0; cc_i = '0; ld_word_i = '0;
   endtask

   // Advance one clock: update model from the driven inputs, land at negedge
   task automatic tick();
      logic [2:0] np;
      np = m_ptr;
      if (ld_we_i) begin
         m_ptr = ld_word_i[13:11];
         m_cc  = {ld_word_i[14], ld_word_i[10], ld_word_i[9], ld_word_i[8]};
         m_sf  = ld_word_i[6];
         m_exc = ld_word_i[5:0];
      end else begin
         if (push_i && !pop_i) np = m_ptr + 3'd7;
         if (pop_i && !push_i) np = m_ptr + 3'd1;
         m_ptr = np;
         m_exc = (clr_exc_i ? 6'd0 : m_exc) | exc_set_i;
         m_sf  = (clr_exc_i ? 1'b0 : m_sf) | sf_set_i;
         if (cc_we_i) m_cc = cc_i;
         if (sf_set_i) m_cc[1] = sf_ovf_i;
      end
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic chk_word(input string req);
      logic [15:0] e;
      e = exp_word();
      chk(sw_o == e, req, sw_o, e);
   endtask

   task automatic load(input logic [15:0] w);
      ld_we_i = 1; ld_word_i = w;
      tick();
   endtask

   initial begin
      #(CLK_PER * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      idle();
      mask_i = 6'h3f;
      rst_n  = 0;
      m_ptr = 0; m_exc = 0; m_sf = 0; m_cc = 0;
      repeat (3) @(negedge clk);
      chk(sw_o == 16'h0000, "R1 in reset", sw_o, 16'h0000);
      rst_n = 1;
      @(negedge clk);
      chk(sw_o == 16'h0000, "R1 after reset", sw_o, 16'h0000);
      chk(err_n_o == 1'b1, "R1 err pin", {15'd0, err_n_o}, 16'd1);

      // R2: walk pointer from each start value
      for (int t = 0; t < 8; t++) begin
         load(16'(t) << 11);
         push_i = 1; tick();
         chk(sw_o[13:11] == 3'(t - 1), "R2 push", {13'd0, sw_o[13:11]}, 16'(3'(t - 1)));
         pop_i = 1; tick();
         chk(sw_o[13:11] == 3'(t), "R2 pop", {13'd0, sw_o[13:11]}, 16'(t));
         push_i = 1; pop_i = 1; tick();
         chk(sw_o[13:11] == 3'(t), "R2 both", {13'd0, sw_o[13:11]}, 16'(t));
      end

      // R3: sticky accumulation
      load(16'h0000);
      mask_i = 6'h00;
      exc_set_i = 6'b000001; tick();
      exc_set_i = 6'b100000; tick();
      tick(); tick();
      chk(sw_o[5:0] == 6'b100001, "R3 sticky", {10'd0, sw_o[5:0]}, 16'h0021);
      chk_word("R3 word");

      // R4: clear with a simultaneous report, C and pointer kept
      cc_we_i = 1; cc_i = 4'b1010; push_i = 1; tick();
      sf_set_i = 1; sf_ovf_i = 1; tick();
      clr_exc_i = 1; exc_set_i = 6'b000100; tick();
      chk(sw_o[6:0] == 7'b0000100, "R4 clear keeps new report", {9'd0, sw_o[6:0]}, 16'h0004);
      chk_word("R4 upper bits kept");

      // R8: stack fault beats condition-code write
      sf_set_i = 1; sf_ovf_i = 1; cc_we_i = 1; cc_i = 4'b0000; tick();
      chk(sw_o[9] == 1'b1 && sw_o[6] == 1'b1, "R8 overflow", sw_o, exp_word());
      sf_set_i = 1; sf_ovf_i = 0; cc_we_i = 1; cc_i = 4'b1111; tick();
      chk(sw_o[9] == 1'b0 && sw_o[6] == 1'b1, "R8 underflow", sw_o, exp_word());
      chk_word("R8 word");

      // R9: every condition-code value
      for (int c = 0; c < 16; c++) begin
         cc_we_i = 1; cc_i = 4'(c); tick();
         chk({sw_o[14], sw_o[10], sw_o[9], sw_o[8]} == 4'(c), "R9 cc write", sw_o, exp_word());
      end

      // R10: loaded bits 7/15 ignored, pin reacts in first cycle
      mask_i = 6'h3f;
      load(16'h80bf);
      chk(sw_o == 16'h003f, "R10 es ignored masked", sw_o, 16'h003f);
      chk(err_n_o == 1'b1, "R10 pin high", {15'd0, err_n_o}, 16'd1);
      mask_i = 6'h3d;
      load(16'h0002);
      chk(sw_o == 16'h8082, "R10 es recomputed", sw_o, 16'h8082);
      chk(err_n_o == 1'b0, "R10 pin low", {15'd0, err_n_o}, 16'd0);
      ld_we_i = 1; ld_word_i = 16'h5a41; push_i = 1; clr_exc_i = 1; exc_set_i = 6'h3e;
      sf_set_i = 1; cc_we_i = 1; cc_i = 4'hf;
      tick();
      chk_word("R10 load overrides");

      // R5/R6/R7: full flag x mask sweep
      for (int f = 0; f < 64; f++) begin
         load(16'(f));
         for (int m = 0; m < 64; m++) begin
            logic e;
            mask_i = 6'(m);
            #(CLK_PER/4);
            e = exp_es(6'(f), 6'(m));
            chk(sw_o[7] == e, "R5 summary", sw_o, {e, 7'd0, e, 7'(f)});
            chk(sw_o[15] == e, "R6 busy mirror", sw_o, {e, 7'd0, e, 7'(f)});
            chk(err_n_o == !e, "R7 error pin", {15'd0, err_n_o}, {15'd0, !e});
         end
         @(negedge clk);
      end

      // Pseudo-random mix against the model (R2 R3 R4 R8 R9 R10)
      lfsr = 32'hace1_2345;
      for (int i = 0; i < 4000; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         push_i    = lfsr[0];
         pop_i     = lfsr[1];
         exc_set_i = (lfsr[4:2] == 3'b000) ? lfsr[10:5] : 6'd0;
         sf_set_i  = (lfsr[13:11] == 3'b111);
         sf_ovf_i  = lfsr[14];
         cc_we_i   = lfsr[15];
         cc_i      = lfsr[19:16];
         clr_exc_i = (lfsr[24:20] == 5'd3);
         ld_we_i   = (lfsr[29:25] == 5'd9);
         ld_word_i = {lfsr[7:0], lfsr[31:24]};
         if (lfsr[31:30] == 2'b11) mask_i = lfsr[27:22];
         tick();
         chk_word("R10 R3 R2 random mix");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule